// File: doc/BRIEF.md
# Word-Serial Radix-2 Montgomery Stage

This block is one processing element of a chain that performs radix-2 Montgomery multiplication on operands split into words. In one pass over the operand words it completes a full outer-loop iteration for a single multiplier bit `x`. The operands are fed least significant word first, one word per clock. Each input word carries a word of the multiplicand Y, a word of the modulus M, and a word of the running partial sum S. S is held in carry-save form as two vectors, `ss` (sum) and `sc` (carry). Y and M arrive in plain binary.

When word 0 arrives, the stage forms S + x·Y and takes the parity of that sum. The parity decides whether M is added in every word of this iteration. For each later word the stage adds the incoming word carries, x·Y, S and, if the parity was odd, M. The adds use two rows of full adders, so the sum stays in carry-save form. Each output word is the computed word shifted right by one bit: its top bit is the low bit of the next computed word. The topmost output word takes the final carry as its top bit. Y and M are passed through beside the new S words, so that identical stages can be chained, each handling the next multiplier bit.

The words of one iteration must arrive on consecutive clock cycles. Iterations may follow one another with or without idle cycles in between. The operand limits are: M odd, M < 2^(W·E−1), Y < M, and S (sum of both vectors) < 2M.

Top module: `mmr2_stage`

## Requirements
- R1: While reset is high, and in the cycles after it until a word is accepted, `out_valid` and `out_first` are low. Input words presented during reset have no effect on the outputs.
- R2: A word sampled at rising edge n appears on the outputs right after edge n+2. Exactly one output word is produced per input word. `out_first` is high on output word 0 of each iteration and only while `out_valid` is high.
- R3: `y_out` and `m_out` carry the Y and M words unchanged, aligned with the S word of the same index.
- R4: With `x_bit` = 1, the value of the E output words (ss plus sc, word j weighted 2^(W·j)) equals (S + Y + q·M)/2. Here q is bit 0 of S + Y, and the operand limits stated above apply.
- R5: With `x_bit` = 0, Y is not added: the output value equals (S + q·M)/2, with q the parity of S.
- R6: `x_bit` is sampled only with the first word of an iteration. Its value on later words has no effect on the result.
- R7: On output word E−1, bit W−1 of `sc_out` is 0, and the final carry of the iteration is placed in bit W−1 of `ss_out`.
- R8: Iterations sent back to back, with no idle cycle between them, each give the result of R4/R5 independently. The word carries and the parity restart at every word 0.
- R9: When no word is presented, no valid output word appears once the pipeline has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operand word is presented this cycle |
| in_first | input | 1 | The presented word is word 0 of an iteration |
| x_bit | input | 1 | Multiplier bit for the iteration, sampled with word 0 |
| y_in | input | W | Multiplicand word |
| m_in | input | W | Modulus word |
| ss_in | input | W | Partial-sum word, sum vector |
| sc_in | input | W | Partial-sum word, carry vector |
| out_valid | output | 1 | An output word is present |
| out_first | output | 1 | The output word is word 0 |
| y_out | output | W | Forwarded multiplicand word |
| m_out | output | W | Forwarded modulus word |
| ss_out | output | W | New partial-sum word, sum vector |
| sc_out | output | W | New partial-sum word, carry vector |

## Verification
The hardest case to reach from the ports is an iteration in which both carry rows ripple a carry through every word boundary into the final carry. Such a case exercises the top-word assembly of R7. The stimulus gets there with operands close to the limits: M just under 2^(W·E−1), Y just under M, and S near 2M split over both vectors. Back-to-back iterations whose final carries differ check that the carry from one iteration does not leak into word 0 of the next. Iterations where `x_bit` flips after word 0 check the sampling rule of R6.

// File: rtl/mmr2_pkg.sv
package mmr2_pkg;

  // Control marks that travel with each word down the pipeline.
  typedef struct packed {
    logic valid;
    logic first;
    logic last;
  } mmr2_tag_t;

endpackage

// File: rtl/mmr2_csa_row.sv
// One row of W full adders: three W-bit vectors in, sum and carry vectors out.
module mmr2_csa_row #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] s,
  output logic [W-1:0] k
);
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i] = a[i] ^ b[i] ^ c[i];
    assign k[i] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
  end
endmodule

// File: rtl/mmr2_word_core.sv
// Combinational word step: two carry-save layers, with carries entering
// from the previous word and leaving toward the next word.
module mmr2_word_core #(
  parameter int W = 16
) (
  input  logic [W-1:0] ss,
  input  logic [W-1:0] sc,
  input  logic [W-1:0] yw,
  input  logic [W-1:0] mw,
  input  logic         xb,
  input  logic         qb,
  input  logic         ci1,
  input  logic         ci2,
  output logic [W-1:0] vs,
  output logic [W-1:0] vc,
  output logic         co1,
  output logic         co2,
  output logic         par
);
  logic [W-1:0] yx, mq, s1, k1, k1s, s2, k2;
  logic [W:0]   sh1, sh2;

  assign yx = xb ? yw : '0;
  assign mq = qb ? mw : '0;

  // Layer 1: S (both vectors) plus x*Y.
  mmr2_csa_row #(.W(W)) u_row1 (
    .a(ss), .b(sc), .c(yx), .s(s1), .k(k1)
  );

  assign sh1 = {k1, ci1};
  assign k1s = sh1[W-1:0];

  // Layer 2: layer-1 result plus q*M.
  mmr2_csa_row #(.W(W)) u_row2 (
    .a(s1), .b(k1s), .c(mq), .s(s2), .k(k2)
  );

  assign sh2 = {k2, ci2};
  assign vs  = s2;
  assign vc  = sh2[W-1:0];
  assign co1 = k1[W-1];
  assign co2 = k2[W-1];
  // Parity of S + x*Y at bit 0 (ci1 is zero on word 0).
  assign par = s1[0] ^ ci1;
endmodule

// File: rtl/mmr2_align.sv
// Holds each computed word one cycle, then assembles the right-shifted
// output word from it and the low bit of the following word.
module mmr2_align #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  mmr2_pkg::mmr2_tag_t a_tag,
  input  logic [W-1:0]        vs,
  input  logic [W-1:0]        vc,
  input  logic [W-1:0]        a_y,
  input  logic [W-1:0]        a_m,
  input  logic                top_bit,
  output logic                o_valid,
  output logic                o_first,
  output logic [W-1:0]        o_y,
  output logic [W-1:0]        o_m,
  output logic [W-1:0]        o_ss,
  output logic [W-1:0]        o_sc
);
  mmr2_pkg::mmr2_tag_t b_tag;
  logic [W-1:0] b_s, b_c, b_y, b_m;

  always_ff @(posedge clk) begin
    if (rst) begin
      b_tag <= '0;
    end else begin
      b_tag.valid <= a_tag.valid;
      if (a_tag.valid) begin
        b_tag.first <= a_tag.first;
        b_tag.last  <= a_tag.last;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (a_tag.valid) begin
      b_s <= vs;
      b_c <= vc;
      b_y <= a_y;
      b_m <= a_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_first <= 1'b0;
    end else begin
      o_valid <= b_tag.valid;
      o_first <= b_tag.valid & b_tag.first;
    end
  end

  always_ff @(posedge clk) begin
    if (b_tag.valid) begin
      o_y  <= b_y;
      o_m  <= b_m;
      o_ss <= {(b_tag.last ? top_bit : vs[0]), b_s[W-1:1]};
      o_sc <= {(b_tag.last ? 1'b0    : vc[0]), b_c[W-1:1]};
    end
  end
endmodule

// File: rtl/mmr2_stage.sv
// Radix-2 word-serial Montgomery processing element (W >= 2).
module mmr2_stage #(
  parameter int W = 16,
  parameter int E = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         x_bit,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] m_in,
  input  logic [W-1:0] ss_in,
  input  logic [W-1:0] sc_in,
  output logic         out_valid,
  output logic         out_first,
  output logic [W-1:0] y_out,
  output logic [W-1:0] m_out,
  output logic [W-1:0] ss_out,
  output logic [W-1:0] sc_out
);
  import mmr2_pkg::*;

  localparam int IW = (E > 1) ? $clog2(E) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(E - 1);

  mmr2_tag_t    a_tag;
  logic [W-1:0] a_y, a_m, a_ss, a_sc;
  logic [IW-1:0] a_idx, n_idx;
  logic         x_hold, q_hold, cr1, cr2;
  logic         q_now, ci1, ci2;
  logic [W-1:0] vs, vc;
  logic         co1, co2, par;

  // Word index of the arriving word.
  assign n_idx = in_first ? '0 : IW'(a_idx + 1'b1);

  // Input capture stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      a_tag  <= '0;
      a_idx  <= '0;
      x_hold <= 1'b0;
    end else begin
      a_tag.valid <= in_valid;
      if (in_valid) begin
        a_tag.first <= in_first;
        a_tag.last  <= (n_idx == LAST_IDX);
        a_idx       <= n_idx;
        if (in_first) x_hold <= x_bit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      a_y  <= y_in;
      a_m  <= m_in;
      a_ss <= ss_in;
      a_sc <= sc_in;
    end
  end

  // Word 0 starts with clear carries and decides the parity on the spot.
  assign ci1   = a_tag.first ? 1'b0 : cr1;
  assign ci2   = a_tag.first ? 1'b0 : cr2;
  assign q_now = a_tag.first ? par  : q_hold;

  mmr2_word_core #(.W(W)) u_core (
    .ss(a_ss), .sc(a_sc), .yw(a_y), .mw(a_m),
    .xb(x_hold), .qb(q_now), .ci1(ci1), .ci2(ci2),
    .vs(vs), .vc(vc), .co1(co1), .co2(co2), .par(par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      q_hold <= 1'b0;
      cr1    <= 1'b0;
      cr2    <= 1'b0;
    end else if (a_tag.valid) begin
      q_hold <= q_now;
      cr1    <= co1;
      cr2    <= co2;
    end
  end

  mmr2_align #(.W(W)) u_align (
    .clk(clk), .rst(rst), .a_tag(a_tag),
    .vs(vs), .vc(vc), .a_y(a_y), .a_m(a_m),
    .top_bit(cr1 | cr2),
    .o_valid(out_valid), .o_first(out_first),
    .o_y(y_out), .o_m(m_out), .o_ss(ss_out), .o_sc(sc_out)
  );
endmodule

// File: rtl/mmr2_stage_chk.sv
module mmr2_stage_chk #(
  parameter int W = 16,
  parameter int E = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_first,
  input logic [W-1:0] y_in,
  input logic [W-1:0] m_in,
  input logic         out_valid,
  input logic         out_first,
  input logic [W-1:0] y_out,
  input logic [W-1:0] m_out,
  input logic [W-1:0] sc_out
);
  logic [1:0] age;
  int unsigned oidx;
  int unsigned cur;
  logic warm;

  always_ff @(posedge clk) begin
    if (rst) begin
      age  <= '0;
      oidx <= 0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (out_valid) oidx <= out_first ? 1 : oidx + 1;
    end
  end

  assign warm = (age == 2'd3);
  assign cur  = out_first ? 0 : oidx;

  // R2: output valid follows input valid three edges later
  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_valid == $past(in_valid, 3)));

  // R2: first mark follows the first word
  p_first_delay_r2: assert property (@(posedge clk) disable iff (rst)
    warm |-> (out_first == ($past(in_valid, 3) && $past(in_first, 3))));

  p_first_has_valid_r2: assert property (@(posedge clk) disable iff (rst)
    out_first |-> out_valid);

  // R3: Y and M forwarded unchanged
  p_fwd_y_r3: assert property (@(posedge clk) disable iff (rst)
    (warm && out_valid) |-> (y_out == $past(y_in, 3)));

  p_fwd_m_r3: assert property (@(posedge clk) disable iff (rst)
    (warm && out_valid) |-> (m_out == $past(m_in, 3)));

  // R7: carry vector top bit is clear on the last word
  p_top_carry_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cur == E - 1) |-> (sc_out[W-1] == 1'b0));
endmodule

bind mmr2_stage mmr2_stage_chk #(.W(W), .E(E)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
  .y_in(y_in), .m_in(m_in), .out_valid(out_valid), .out_first(out_first),
  .y_out(y_out), .m_out(m_out), .sc_out(sc_out)
);

// File: tb/mmr2_stage_tb.sv
`timescale 1ns/1ps
module mmr2_stage_tb;
  localparam int W  = 8;
  localparam int E  = 4;
  localparam int K  = W * E;
  localparam int NV = 6;

  // {x, Y, M, S sum vector, S carry vector}
  localparam logic [4*K:0] TBL [NV] = '{
    {1'b1, 32'h1234_5678, 32'h7FFF_FFFF, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 32'h5555_5555, 32'h6543_2101, 32'h4000_0001, 32'h3000_0000},
    {1'b0, 32'h0000_0001, 32'h0000_0003, 32'h0000_0001, 32'h0000_0002},
    {1'b1, 32'h7ABC_DEF0, 32'h7ABC_DEF1, 32'h8000_0000, 32'h7000_0000},
    {1'b0, 32'h0FFF_FFFF, 32'h1357_9BDF, 32'h1111_1111, 32'h0101_0101},
    {1'b1, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000}
  };

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_first, x_bit;
  logic [W-1:0] y_in, m_in, ss_in, sc_in;
  logic out_valid, out_first;
  logic [W-1:0] y_out, m_out, ss_out, sc_out;

  always #4 clk = ~clk;

  mmr2_stage #(.W(W), .E(E)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .x_bit(x_bit), .y_in(y_in), .m_in(m_in), .ss_in(ss_in), .sc_in(sc_in),
    .out_valid(out_valid), .out_first(out_first), .y_out(y_out),
    .m_out(m_out), .ss_out(ss_out), .sc_out(sc_out)
  );

  int n_chk = 0, n_bad = 0, n_in = 0, n_out = 0, oidx = 0;
  logic [K-1:0] ex_val [64];
  logic [K-1:0] ex_y [64];
  logic [K-1:0] ex_m [64];
  string        ex_tag [64];
  logic [K-1:0] acc_s, acc_c, acc_y, acc_m;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  // Output collector and value checks.
  always @(negedge clk) begin
    int w;
    logic [K:0] tot;
    if (!rst && out_valid) begin
      w = out_first ? 0 : oidx;
      if (w < E) begin
        acc_s[w*W +: W] = ss_out;
        acc_c[w*W +: W] = sc_out;
        acc_y[w*W +: W] = y_out;
        acc_m[w*W +: W] = m_out;
      end
      oidx = w + 1;
      if (w == E - 1) begin
        tot = {1'b0, acc_s} + {1'b0, acc_c};
        chk(n_out < n_in, "R2 unexpected output iteration", 64'(n_out), 64'(n_in));
        if (n_out < n_in) begin
          chk(tot == {1'b0, ex_val[n_out]}, ex_tag[n_out], 64'(tot), 64'(ex_val[n_out]));
          chk(acc_y == ex_y[n_out], "R3 Y forwarding", 64'(acc_y), 64'(ex_y[n_out]));
          chk(acc_m == ex_m[n_out], "R3 M forwarding", 64'(acc_m), 64'(ex_m[n_out]));
        end
        chk(sc_out[W-1] == 1'b0, "R7 top carry-vector bit", 64'(sc_out[W-1]), 64'd0);
        n_out++;
      end
    end
  end

  task automatic run_iter(input logic [4*K:0] t, input int gap, input bit tog,
                          input bit lat, input string tag);
    logic xv;
    logic [K-1:0] yv, mv, sav, sbv;
    logic [K+1:0] tot;
    xv  = t[4*K];
    yv  = t[4*K-1:3*K];
    mv  = t[3*K-1:2*K];
    sav = t[2*K-1:K];
    sbv = t[K-1:0];
    tot = {2'b00, sav} + {2'b00, sbv} + (xv ? {2'b00, yv} : '0);
    if (tot[0]) tot = tot + {2'b00, mv};
    ex_val[n_in] = tot[K:1];
    ex_y[n_in]   = yv;
    ex_m[n_in]   = mv;
    ex_tag[n_in] = tag;
    n_in++;
    for (int k = 0; k < E; k++) begin
      if (lat && k > 0) begin
        chk(out_valid == (k >= 3), "R2 output valid timing", 64'(out_valid), 64'(k >= 3));
        if (k == 3) chk(out_first == 1'b1, "R2 first mark timing", 64'(out_first), 64'd1);
      end
      in_valid = 1'b1;
      in_first = (k == 0);
      x_bit    = (k == 0) ? xv : (tog ? ~xv : xv);
      y_in     = yv[k*W +: W];
      m_in     = mv[k*W +: W];
      ss_in    = sav[k*W +: W];
      sc_in    = sbv[k*W +: W];
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_first = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_out, n_in);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b1; in_first = 1'b1; x_bit = 1'b1;
    y_in = '1; m_in = '1; ss_in = '1; sc_in = '1;
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low in reset", 64'(out_valid), 64'd0);
    chk(out_first == 1'b0, "R1 first low in reset", 64'(out_first), 64'd0);
    rst = 1'b0; in_valid = 1'b0; in_first = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid low after reset", 64'(out_valid), 64'd0);
    end

    // Table walk; the first entry also checks latency.
    for (int i = 0; i < NV; i++)
      run_iter(TBL[i], 4, 1'b0, (i == 0), TBL[i][4*K] ? "R4 value x=1" : "R5 value x=0");

    // R8: back-to-back iterations with differing final carries.
    run_iter(TBL[3], 0, 1'b0, 1'b0, "R8 back-to-back a");
    run_iter(TBL[1], 0, 1'b0, 1'b0, "R8 back-to-back b");
    run_iter(TBL[4], 0, 1'b0, 1'b0, "R8 back-to-back c");
    run_iter(TBL[5], 5, 1'b0, 1'b0, "R8 back-to-back d");

    // R6: x_bit flips after word 0.
    run_iter(TBL[1], 4, 1'b1, 1'b0, "R6 x toggled x=1");
    run_iter(TBL[4], 4, 1'b1, 1'b1, "R6 x toggled x=0");

    // R9: idle produces nothing.
    repeat (6) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9 idle valid", 64'(out_valid), 64'd0);
    end
    chk(n_out == n_in, "R2 output iteration count", 64'(n_out), 64'(n_in));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule